// File: doc/BRIEF.md
# Flash write-protection controller

This block holds the write-protection settings of a serial NOR flash array and gives a grant or deny for every program or erase request. A three-bit protect code sets the size of a protected region. The region grows by powers of two, and it is anchored at either the top or the bottom of the array. A per-sector protect input from outside is combined with the range check by OR. Requests that target the one-time-programmable (OTP) area are judged by a separate rule.

A sticky freeze bit locks the protect code and the anchor bit. Once the freeze bit is set, register writes are dropped silently. Only power-on reset clears the freeze bit. The command decoder presents register writes through a one-cycle write strobe. The program/erase engine presents a request address, together with flags that mark an OTP target or a locked sector, and it reads the grant in the same cycle.

Top module: `flash_wp_ctrl`

## Requirements
- R1: With protect code 3'b000, no main-array address is denied by the range check.
- R2: With anchor bit 0 and protect code c from 3'b001 to 3'b110, the highest (2^(c-1))/64 of the array is denied and every lower address is granted.
- R3: With anchor bit 1 and protect code c from 3'b001 to 3'b110, the lowest (2^(c-1))/64 of the array is denied, starting at address 0, and every higher address is granted.
- R4: With protect code 3'b111, every main-array address is denied, whatever the anchor bit.
- R5: A main-array request is denied when `req_sect_lock` is 1, even if the range check would grant it.
- R6: While the freeze bit is 0, a write strobe loads the code, the anchor bit and the freeze bit at the next clock edge. `grant` follows the address and the stored state without a clock.
- R7: Once the freeze bit is 1, it stays 1 until power-on reset.
- R8: While the freeze bit is 1, write strobes leave the code and the anchor bit unchanged, and no other output changes.
- R9: An OTP request (`req_otp` = 1) is granted while the freeze bit is 0 and denied while it is 1.
- R10: Power-on reset clears the code, the anchor bit and the freeze bit. The synchronous system reset clears the code and the anchor bit only while the freeze bit is 0, and it never changes the freeze bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous system reset, active low |
| wr_en | input | 1 | One-cycle write strobe for the settings |
| wr_code | input | 3 | New protect code |
| wr_bottom | input | 1 | New anchor bit (0 = top, 1 = bottom) |
| wr_freeze | input | 1 | New freeze bit |
| req_addr | input | ADDR_W | Byte address of the program/erase request |
| req_otp | input | 1 | Request targets the OTP area |
| req_sect_lock | input | 1 | External protect flag of the addressed sector |
| grant | output | 1 | 1 = request allowed, 0 = denied |
| prot_code | output | 3 | Stored protect code |
| bottom_sel | output | 1 | Stored anchor bit |
| frozen | output | 1 | Stored freeze bit |

## Verification
The assertions assume that both resets are driven to known levels from the first clock edge. They also assume that the write strobe is never X while power-on reset is released, and that `req_otp` and `req_sect_lock` are stable when `grant` is sampled. The stimulus changes every input on the falling clock edge only. It keeps `sys_rst_n` high during writes, except in the one test that checks a system reset under freeze. Request addresses always lie inside the array, so each boundary probe at one byte below or above an edge is a real address.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int CODE_W = 3;
  // Codes 1..(2^CODE_W - 2) double the region; the top code covers all.
  localparam int FRAC_W = (1 << CODE_W) - 2;
  localparam int SPAN_W = FRAC_W + 1;
  localparam logic [CODE_W-1:0] CODE_NONE = '0;
  localparam logic [CODE_W-1:0] CODE_ALL  = '1;

  // Number of 1/2^FRAC_W slices covered by a code.
  function automatic logic [SPAN_W-1:0] wp_span(logic [CODE_W-1:0] code);
    logic [SPAN_W-1:0] one;
    one = SPAN_W'(1);
    if (code == CODE_NONE) return '0;
    return one << (code - 1'b1);
  endfunction

  // Range membership of an address slice index, no division needed.
  function automatic logic wp_covers(logic [FRAC_W-1:0] slice,
                                     logic [CODE_W-1:0] code,
                                     logic bottom);
    logic [SPAN_W-1:0] n;
    logic [SPAN_W-1:0] s;
    logic [SPAN_W-1:0] full;
    n    = wp_span(code);
    s    = {1'b0, slice};
    full = SPAN_W'(1) << FRAC_W;
    if (bottom) return s < n;
    return s >= (full - n);
  endfunction
endpackage

// File: rtl/wp_regs.sv
module wp_regs
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_bottom,
  input  logic              wr_freeze,
  output logic [CODE_W-1:0] code_q,
  output logic              bottom_q,
  output logic              frozen_q,
  output logic              wr_accept
);
  assign wr_accept = wr_en & ~frozen_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      code_q   <= CODE_NONE;
      bottom_q <= 1'b0;
      frozen_q <= 1'b0;
    end else if (!sys_rst_n) begin
      if (!frozen_q) begin
        code_q   <= CODE_NONE;
        bottom_q <= 1'b0;
      end
    end else if (wr_accept) begin
      code_q   <= wr_code;
      bottom_q <= wr_bottom;
      frozen_q <= wr_freeze;
    end
  end
endmodule

// File: rtl/wp_range.sv
module wp_range
  import wp_pkg::*;
(
  input  logic [FRAC_W-1:0] slice,
  input  logic [CODE_W-1:0] code,
  input  logic              bottom,
  output logic              hit
);
  assign hit = wp_covers(slice, code, bottom);
endmodule

// File: rtl/wp_decide.sv
module wp_decide (
  input  logic range_hit,
  input  logic sect_lock,
  input  logic otp,
  input  logic frozen,
  output logic grant
);
  logic main_deny;
  assign main_deny = range_hit | sect_lock;
  assign grant     = otp ? ~frozen : ~main_deny;
endmodule

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl
  import wp_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              wr_bottom,
  input  logic              wr_freeze,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_otp,
  input  logic              req_sect_lock,
  output logic              grant,
  output logic [CODE_W-1:0] prot_code,
  output logic              bottom_sel,
  output logic              frozen
);
  localparam int LOW_W = ADDR_W - FRAC_W;

  logic [FRAC_W-1:0] slice;
  logic              range_hit;
  logic              wr_accept;
  logic              unused_low;

  assign slice      = req_addr[ADDR_W-1 -: FRAC_W];
  assign unused_low = ^req_addr[LOW_W-1:0];

  wp_regs u_regs (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .wr_en     (wr_en),
    .wr_code   (wr_code),
    .wr_bottom (wr_bottom),
    .wr_freeze (wr_freeze),
    .code_q    (prot_code),
    .bottom_q  (bottom_sel),
    .frozen_q  (frozen),
    .wr_accept (wr_accept)
  );

  wp_range u_range (
    .slice  (slice),
    .code   (prot_code),
    .bottom (bottom_sel),
    .hit    (range_hit)
  );

  wp_decide u_decide (
    .range_hit (range_hit),
    .sect_lock (req_sect_lock),
    .otp       (req_otp),
    .frozen    (frozen),
    .grant     (grant)
  );
endmodule

// File: rtl/wp_checker.sv
module wp_checker
  import wp_pkg::*;
(
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              wr_accept,
  input logic [CODE_W-1:0] wr_code,
  input logic              wr_bottom,
  input logic              wr_freeze,
  input logic              req_otp,
  input logic              req_sect_lock,
  input logic              range_hit,
  input logic              grant,
  input logic [CODE_W-1:0] prot_code,
  input logic              bottom_sel,
  input logic              frozen
);
  p_none_r1: assert property (@(posedge clk) disable iff (!por_n)
    (prot_code == CODE_NONE) |-> !range_hit);

  p_range_deny_r2: assert property (@(posedge clk) disable iff (!por_n)
    (range_hit && !req_otp) |-> !grant);

  p_all_r4: assert property (@(posedge clk) disable iff (!por_n)
    (prot_code == CODE_ALL && !req_otp) |-> !grant);

  p_sect_lock_r5: assert property (@(posedge clk) disable iff (!por_n)
    (req_sect_lock && !req_otp) |-> !grant);

  p_write_load_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_accept && sys_rst_n) |=> (prot_code == $past(wr_code)) &&
      (bottom_sel == $past(wr_bottom)) && (frozen == $past(wr_freeze)));

  p_freeze_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
    frozen |=> frozen);

  p_frozen_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    frozen |=> $stable(prot_code) && $stable(bottom_sel));

  p_otp_r9: assert property (@(posedge clk) disable iff (!por_n)
    req_otp |-> (grant == !frozen));

  p_sys_reset_r10: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && !frozen) |=> (prot_code == CODE_NONE) && !bottom_sel && !frozen);
endmodule

bind flash_wp_ctrl wp_checker chk_i (
  .clk           (clk),
  .por_n         (por_n),
  .sys_rst_n     (sys_rst_n),
  .wr_accept     (wr_accept),
  .wr_code       (wr_code),
  .wr_bottom     (wr_bottom),
  .wr_freeze     (wr_freeze),
  .req_otp       (req_otp),
  .req_sect_lock (req_sect_lock),
  .range_hit     (range_hit),
  .grant         (grant),
  .prot_code     (prot_code),
  .bottom_sel    (bottom_sel),
  .frozen        (frozen)
);

// File: tb/flash_wp_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_wp_ctrl_tb_top;
  localparam int ADDR_W = 24;
  localparam longint ARR = longint'(1) << ADDR_W;

  logic              clk = 1'b0;
  logic              por_n = 1'b0;
  logic              sys_rst_n = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        wr_code = '0;
  logic              wr_bottom = 1'b0;
  logic              wr_freeze = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_otp = 1'b0;
  logic              req_sect_lock = 1'b0;
  logic              grant;
  logic [2:0]        prot_code;
  logic              bottom_sel;
  logic              frozen;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic        exp;
    longint      addr;
    string       tag;
  } item_t;
  item_t sb_q[$];
  event  probe_ev;

  always #2.5 clk = ~clk;

  flash_wp_ctrl #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .wr_en(wr_en), .wr_code(wr_code), .wr_bottom(wr_bottom), .wr_freeze(wr_freeze),
    .req_addr(req_addr), .req_otp(req_otp), .req_sect_lock(req_sect_lock),
    .grant(grant), .prot_code(prot_code), .bottom_sel(bottom_sel), .frozen(frozen)
  );

  // Bench model: bytes protected = ARR/64 * 2^(code-1), code 0 -> none.
  function automatic bit exp_deny(longint a, int code, bit bottom);
    longint sz;
    sz = (code == 0) ? 0 : (ARR / 64) * (longint'(1) << (code - 1));
    if (bottom) return a < sz;
    return a >= (ARR - sz);
  endfunction

  // Monitor: pops expected items and compares against grant.
  initial begin
    forever begin
      @(probe_ev);
      #0.5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (grant !== it.exp) begin
          fails++;
          $display("FAIL %s addr=%h actual=%0b expected=%0b", it.tag, it.addr, grant, it.exp);
        end
      end
    end
  end

  task automatic probe(longint a, bit lock, bit otp, bit exp_grant, string tag);
    item_t it;
    @(negedge clk);
    req_addr      = a[ADDR_W-1:0];
    req_sect_lock = lock;
    req_otp       = otp;
    it.exp = exp_grant; it.addr = a; it.tag = tag;
    sb_q.push_back(it);
    -> probe_ev;
    #1;
  endtask

  task automatic write_regs(int code, bit bottom, bit frz);
    @(negedge clk);
    wr_en = 1'b1; wr_code = code[2:0]; wr_bottom = bottom; wr_freeze = frz;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_state(int code, bit bottom, bit frz, string tag);
    @(negedge clk);
    checks++;
    if (prot_code !== code[2:0] || bottom_sel !== bottom || frozen !== frz) begin
      fails++;
      $display("FAIL %s state actual=%0d/%0b/%0b expected=%0d/%0b/%0b",
               tag, prot_code, bottom_sel, frozen, code, bottom, frz);
    end
  endtask

  function automatic string code_tag(int code, bit bottom);
    if (code == 0) return "R1";
    if (code == 7) return "R4";
    return bottom ? "R3" : "R2";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    check_state(0, 0, 0, "R10 por");

    // Sweep codes and anchors at the region edges.
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 8; c++) begin
        longint sz;
        longint edge_a;
        longint cand[5];
        write_regs(c, b[0], 1'b0);
        check_state(c, b[0], 0, "R6 load");
        sz = (c == 0) ? 0 : (ARR / 64) * (longint'(1) << (c - 1));
        edge_a = b[0] ? sz : ARR - sz;
        cand[0] = edge_a - 1; cand[1] = edge_a; cand[2] = edge_a + 1;
        cand[3] = 0; cand[4] = ARR - 1;
        for (int k = 0; k < 5; k++) begin
          if (cand[k] >= 0 && cand[k] < ARR)
            probe(cand[k], 1'b0, 1'b0, !exp_deny(cand[k], c, b[0]), code_tag(c, b[0]));
        end
      end
    end

    // R5: sector lock overrides an otherwise granted address.
    write_regs(1, 1'b0, 1'b0);
    probe(0, 1'b1, 1'b0, 1'b0, "R5 lock");
    probe(0, 1'b0, 1'b0, 1'b1, "R5 unlock");
    probe(ARR - 1, 1'b1, 1'b0, 1'b0, "R5 lock in range");

    // R9: OTP allowed while unfrozen.
    probe(ARR - 1, 1'b0, 1'b1, 1'b1, "R9 otp unfrozen");

    // R10: system reset while unfrozen clears the settings.
    write_regs(5, 1'b1, 1'b0);
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    check_state(0, 0, 0, "R10 sysrst unfrozen");

    // Freeze with code 3, top anchor.
    write_regs(3, 1'b0, 1'b1);
    check_state(3, 0, 1, "R7 freeze set");
    write_regs(5, 1'b1, 1'b0);
    check_state(3, 0, 1, "R8 write dropped");
    probe(ARR - 1, 1'b0, 1'b0, 1'b0, "R8 range kept");
    probe(ARR - (ARR / 16) - 1, 1'b0, 1'b0, 1'b1, "R8 below kept");
    probe(0, 1'b0, 1'b1, 1'b0, "R9 otp frozen");

    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    check_state(3, 0, 1, "R10 sysrst frozen");
    check_state(3, 0, 1, "R7 still frozen");

    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    check_state(0, 0, 0, "R10 por clears freeze");
    probe(0, 1'b0, 1'b1, 1'b1, "R9 otp after por");

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule